// File: doc/BRIEF.md
# Outbound Address Translation Window Unit

This block sits on the local CPU side of an outbound request path. Every CPU read or write is checked against a fixed 64 MB aperture. The default aperture starts at local address 0xF800_0000 and ends at 0xFBFF_FFFF. An access inside the aperture is assigned to one of 33 windows. Window 0 is a single 32 MB window. Windows 1 to 32 are 1 MB each.

For a hit, the local address is replaced by the remote base programmed for that window. The offset inside the window is kept in the low bits. The request then leaves with that window's two descriptor words, the window number and the write data. An access outside the aperture is not translated: it is passed through unchanged and flagged as a miss.

The translation registers are kept in a small register file on a 32-bit register bus, with one slot block per window. Reserved slots in that map read as zero and ignore writes. Requests enter and leave through valid/ready handshakes, with one register stage between them.

Top module: `obx_top`

## Requirements
- R1: After reset, every register in the map reads zero and `out_valid_o` is low.
- R2: An access with `req_addr_i` below 0xF800_0000 or above 0xFBFF_FFFF produces `out_miss_o`=1. On a miss, `out_addr_o` equals `req_addr_i` zero-extended to 64 bits, both descriptor outputs are zero and `out_win_o` is 0.
- R3: An access at aperture offset 0 to 0x01FF_FFFF selects window 0. Its `out_addr_o` is the window's 64-bit base {addr1, addr0}, with bits 24:0 replaced by offset bits 24:0.
- R4: Aperture offset 0x0200_0000 + (n-1)*0x10_0000 up to the end of that 1 MB selects window n (1..32). Its `out_addr_o` is that window's base, with bits 19:0 replaced by offset bits 19:0.
- R5: On a hit, `out_desc0_o` and `out_desc1_o` carry the selected window's two descriptor registers, and `out_win_o` carries its number.
- R6: The registers of window w start at byte address w*0x20. The slots are: 0x00 addr0 (remote bits 31:0), 0x04 addr1 (remote bits 63:32), 0x08 descriptor 0 and 0x0C descriptor 1. A write to one of these slots is read back unchanged. `reg_rdata_o` follows `reg_addr_i` in the same cycle.
- R7: Slots 0x10 to 0x1C of every window are reserved, and so is every address at or above 33*0x20. Writes there change no register, and reads there return zero.
- R8: An accepted request (`req_valid_i` and `req_ready_o` both high at a clock edge) appears with `out_valid_o` high after that edge. `req_ready_o` is high whenever the output stage is empty or `out_ready_i` is high.
- R9: While `out_valid_o` is high and `out_ready_i` is low, every output stays stable and `req_ready_o` is low.
- R10: `out_write_o` and `out_wdata_o` repeat the accepted request's `req_write_i` and `req_wdata_i`, for hits and misses alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 11 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| req_valid_i | input | 1 | Local request valid |
| req_ready_o | output | 1 | Local request ready |
| req_addr_i | input | 32 | Local address |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_wdata_i | input | 32 | Write data |
| out_valid_o | output | 1 | Translated request valid |
| out_ready_i | input | 1 | Downstream ready |
| out_addr_o | output | 64 | Remote address, or local address on miss |
| out_write_o | output | 1 | Forwarded direction |
| out_wdata_o | output | 32 | Forwarded write data |
| out_desc0_o | output | 32 | Window descriptor word 0 |
| out_desc1_o | output | 32 | Window descriptor word 1 |
| out_win_o | output | 6 | Selected window number |
| out_miss_o | output | 1 | Access fell outside the aperture |

## Verification
The hardest case to reach from the ports is the handoff under backpressure. A second request has to wait while the first is held, and then both must move on the same edge that releases the first. The bench stalls `out_ready_i`, keeps a second request pending, and checks that the held output does not change. It then raises ready for one edge and checks that the second request follows without a gap. The window boundaries on both sides of the 32 MB / 1 MB split and at the top of the aperture are also driven. Each window is given a distinct base, so a wrong window index shows up as a wrong address.

// File: rtl/obx_pkg.sv
package obx_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned RADDR_W = 64;
  localparam int unsigned WIN_W   = 6;

  typedef struct packed {
    logic [RADDR_W-1:0] addr;
    logic               write;
    logic [DATA_W-1:0]  wdata;
    logic [DATA_W-1:0]  desc0;
    logic [DATA_W-1:0]  desc1;
    logic [WIN_W-1:0]   win;
    logic               miss;
  } obx_req_t;
endpackage

// File: rtl/obx_win_decode.sv
module obx_win_decode
  import obx_pkg::*;
#(
  parameter int unsigned          AW         = 32,
  parameter logic [AW-1:0]        APT_BASE   = 32'hF800_0000,
  parameter int unsigned          BIG_BITS   = 25,
  parameter int unsigned          SMALL_BITS = 20,
  parameter int unsigned          NUM_SMALL  = 32
) (
  input  logic [AW-1:0]      addr_i,
  output logic               hit_o,
  output logic [WIN_W-1:0]   win_o,
  output logic [RADDR_W-1:0] keep_mask_o
);
  localparam logic [63:0] BIG_SIZE   = 64'd1 << BIG_BITS;
  localparam logic [63:0] SMALL_SIZE = 64'd1 << SMALL_BITS;
  localparam logic [63:0] APT_SIZE   = BIG_SIZE + 64'(NUM_SMALL) * SMALL_SIZE;
  localparam logic [63:0] APT_LO     = 64'(APT_BASE);
  localparam logic [63:0] APT_HI     = APT_LO + APT_SIZE - 64'd1;

  logic [63:0] addr_w, off, small_off;

  always_comb begin
    addr_w      = 64'(addr_i);
    off         = addr_w - APT_LO;
    small_off   = off - BIG_SIZE;
    hit_o       = (addr_w >= APT_LO) && (addr_w <= APT_HI);
    win_o       = '0;
    keep_mask_o = '0;
    if (hit_o) begin
      if (off < BIG_SIZE) begin
        win_o       = '0;
        keep_mask_o = RADDR_W'(BIG_SIZE - 64'd1);
      end else begin
        win_o       = WIN_W'(small_off >> SMALL_BITS) + WIN_W'(1);
        keep_mask_o = RADDR_W'(SMALL_SIZE - 64'd1);
      end
    end
  end
endmodule

// File: rtl/obx_win_regs.sv
module obx_win_regs
  import obx_pkg::*;
#(
  parameter int unsigned NWIN = 33
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [WIN_W+4:0]  addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [WIN_W-1:0]  lk_win_i,
  output logic [DATA_W-1:0] lk_addr0_o,
  output logic [DATA_W-1:0] lk_addr1_o,
  output logic [DATA_W-1:0] lk_desc0_o,
  output logic [DATA_W-1:0] lk_desc1_o
);
  localparam int unsigned NSLOT = 4;

  logic [NWIN-1:0][DATA_W-1:0] addr0_q, addr1_q, desc0_q, desc1_q;
  logic [WIN_W-1:0] win_sel;
  logic [2:0]       slot;
  logic             win_ok, slot_ok, wr_ok;

  assign win_sel = addr_i[WIN_W+4:5];
  assign slot    = addr_i[4:2];
  assign win_ok  = 32'(win_sel) < NWIN;
  assign slot_ok = 32'(slot) < NSLOT;
  assign wr_ok   = we_i && win_ok && slot_ok;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr0_q[w] <= '0;
        addr1_q[w] <= '0;
        desc0_q[w] <= '0;
        desc1_q[w] <= '0;
      end else if (wr_ok && (32'(win_sel) == w)) begin
        case (slot)
          3'd0:    addr0_q[w] <= wdata_i;
          3'd1:    addr1_q[w] <= wdata_i;
          3'd2:    desc0_q[w] <= wdata_i;
          3'd3:    desc1_q[w] <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (win_ok) begin
      case (slot)
        3'd0:    rdata_o = addr0_q[win_sel];
        3'd1:    rdata_o = addr1_q[win_sel];
        3'd2:    rdata_o = desc0_q[win_sel];
        3'd3:    rdata_o = desc1_q[win_sel];
        default: rdata_o = '0;
      endcase
    end
  end

  always_comb begin
    lk_addr0_o = '0;
    lk_addr1_o = '0;
    lk_desc0_o = '0;
    lk_desc1_o = '0;
    if (32'(lk_win_i) < NWIN) begin
      lk_addr0_o = addr0_q[lk_win_i];
      lk_addr1_o = addr1_q[lk_win_i];
      lk_desc0_o = desc0_q[lk_win_i];
      lk_desc1_o = desc1_q[lk_win_i];
    end
  end

  AST_RSVD_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !(win_ok && slot_ok)) |=>
      ($stable(addr0_q) && $stable(addr1_q) && $stable(desc0_q) && $stable(desc1_q))) // R7
    else $error("reserved write changed state");
endmodule

// File: rtl/obx_out_stage.sv
module obx_out_stage
  import obx_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     in_valid_i,
  output logic     in_ready_o,
  input  obx_req_t in_data_i,
  output logic     out_valid_o,
  input  logic     out_ready_i,
  output obx_req_t out_data_o
);
  logic     valid_q;
  obx_req_t data_q;

  assign in_ready_o  = !valid_q || out_ready_i;
  assign out_valid_o = valid_q;
  assign out_data_o  = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (in_ready_o) begin
      valid_q <= in_valid_i;
      if (in_valid_i) data_q <= in_data_i;
    end
  end

  AST_HOLD_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> out_valid_o) // R9
    else $error("valid dropped under stall");
  AST_HOLD_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> $stable(out_data_o)) // R9
    else $error("data changed under stall");
  AST_ACCEPT_SHOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> out_valid_o) // R8
    else $error("accepted request missing");
endmodule

// File: rtl/obx_top.sv
module obx_top
  import obx_pkg::*;
#(
  parameter logic [31:0] APT_BASE   = 32'hF800_0000,
  parameter int unsigned BIG_BITS   = 25,
  parameter int unsigned SMALL_BITS = 20,
  parameter int unsigned NUM_SMALL  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [10:0]        reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [31:0]        req_addr_i,
  input  logic               req_write_i,
  input  logic [DATA_W-1:0]  req_wdata_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [RADDR_W-1:0] out_addr_o,
  output logic               out_write_o,
  output logic [DATA_W-1:0]  out_wdata_o,
  output logic [DATA_W-1:0]  out_desc0_o,
  output logic [DATA_W-1:0]  out_desc1_o,
  output logic [WIN_W-1:0]   out_win_o,
  output logic               out_miss_o
);
  localparam int unsigned NWIN = NUM_SMALL + 1;
  localparam logic [63:0] APT_END =
    64'(APT_BASE) + (64'd1 << BIG_BITS) + 64'(NUM_SMALL) * (64'd1 << SMALL_BITS);

  logic               hit;
  logic [WIN_W-1:0]   win;
  logic [RADDR_W-1:0] keep_mask, base, local_w;
  logic [DATA_W-1:0]  a0, a1, d0, d1;
  obx_req_t           nxt, cur;

  obx_win_decode #(
    .AW(32), .APT_BASE(APT_BASE), .BIG_BITS(BIG_BITS),
    .SMALL_BITS(SMALL_BITS), .NUM_SMALL(NUM_SMALL)
  ) u_dec (
    .addr_i(req_addr_i), .hit_o(hit), .win_o(win), .keep_mask_o(keep_mask)
  );

  obx_win_regs #(.NWIN(NWIN)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .lk_win_i(win), .lk_addr0_o(a0), .lk_addr1_o(a1), .lk_desc0_o(d0), .lk_desc1_o(d1)
  );

  assign base    = {a1, a0};
  assign local_w = RADDR_W'(req_addr_i);

  always_comb begin
    nxt       = '0;
    nxt.write = req_write_i;
    nxt.wdata = req_wdata_i;
    nxt.miss  = !hit;
    if (hit) begin
      // keep window offset, take the rest from the programmed base
      nxt.addr  = (base & ~keep_mask) | (local_w & keep_mask);
      nxt.desc0 = d0;
      nxt.desc1 = d1;
      nxt.win   = win;
    end else begin
      nxt.addr  = local_w;
    end
  end

  obx_out_stage u_stage (
    .clk_i, .rst_ni,
    .in_valid_i(req_valid_i), .in_ready_o(req_ready_o), .in_data_i(nxt),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_data_o(cur)
  );

  assign out_addr_o  = cur.addr;
  assign out_write_o = cur.write;
  assign out_wdata_o = cur.wdata;
  assign out_desc0_o = cur.desc0;
  assign out_desc1_o = cur.desc1;
  assign out_win_o   = cur.win;
  assign out_miss_o  = cur.miss;

  AST_OUTSIDE_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o &&
     ((64'(req_addr_i) < 64'(APT_BASE)) || (64'(req_addr_i) >= APT_END)))
    |=> (out_miss_o && out_addr_o == 64'($past(req_addr_i)))) // R2
    else $error("outside access not flagged");
  AST_WIN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_miss_o) |-> (32'(out_win_o) < NWIN)) // R4
    else $error("window index out of range");
  AST_MISS_NO_DESC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_miss_o) |-> (out_desc0_o == '0 && out_desc1_o == '0)) // R2
    else $error("descriptor leaked on miss");
  AST_READY_RULE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !req_ready_o) // R9
    else $error("ready while stalled");
endmodule

// File: tb/tb_obx_top.sv
module tb_obx_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [10:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_addr;
  logic        out_write;
  logic [31:0] out_wdata, out_desc0, out_desc1;
  logic [5:0]  out_win;
  logic        out_miss;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] m_a0 [33];
  logic [31:0] m_a1 [33];
  logic [31:0] m_d0 [33];
  logic [31:0] m_d1 [33];

  always #10 clk = ~clk;

  obx_top dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_write_i(req_write), .req_wdata_i(req_wdata),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_addr_o(out_addr),
    .out_write_o(out_write), .out_wdata_o(out_wdata), .out_desc0_o(out_desc0),
    .out_desc1_o(out_desc1), .out_win_o(out_win), .out_miss_o(out_miss)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(logic [10:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd_chk(string tag, logic [10:0] a, logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 chk(tag, 64'(reg_rdata), 64'(exp));
  endtask

  function automatic logic [63:0] exp_addr(int w, logic [31:0] a);
    logic [63:0] m;
    logic [63:0] off;
    off = 64'(a) - 64'hF800_0000;
    m = (w == 0) ? ((64'd1 << 25) - 1) : ((64'd1 << 20) - 1);
    return ({m_a1[w], m_a0[w]} & ~m) | (off & m);
  endfunction

  // accept one request and check the output on the following half cycle
  task automatic send(logic [31:0] a, logic wr, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_wdata = d;
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk_hit(string tag, logic [31:0] a, int w);
    send(a, 1'b1, a ^ 32'h5A5A_0000);
    chk({tag, " valid R8"}, 64'(out_valid), 64'd1);
    chk({tag, " miss R2"}, 64'(out_miss), 64'd0);
    chk({tag, " addr R3/R4"}, out_addr, exp_addr(w, a));
    chk({tag, " win R5"}, 64'(out_win), 64'(w));
    chk({tag, " desc0 R5"}, 64'(out_desc0), 64'(m_d0[w]));
    chk({tag, " desc1 R5"}, 64'(out_desc1), 64'(m_d1[w]));
    chk({tag, " wdata R10"}, 64'(out_wdata), 64'(a ^ 32'h5A5A_0000));
    chk({tag, " write R10"}, 64'(out_write), 64'd1);
  endtask

  task automatic t_reset();
    chk("R1 out_valid after reset", 64'(out_valid), 64'd0);
    reg_rd_chk("R1 addr0 w0", 11'h000, 32'h0);
    reg_rd_chk("R1 desc1 w32", 11'h40C, 32'h0);
    reg_rd_chk("R1 addr1 w17", 11'h224, 32'h0);
  endtask

  task automatic t_regmap();
    for (int w = 0; w < 33; w++) begin
      m_a0[w] = 32'hA000_0000 + 32'(w) * 32'h0011_1111;
      m_a1[w] = 32'h1000_0000 | 32'(w);
      m_d0[w] = 32'hD000_0000 + 32'(w);
      m_d1[w] = ~32'(w);
      reg_wr(11'(w * 32 + 0),  m_a0[w]);
      reg_wr(11'(w * 32 + 4),  m_a1[w]);
      reg_wr(11'(w * 32 + 8),  m_d0[w]);
      reg_wr(11'(w * 32 + 12), m_d1[w]);
    end
    reg_rd_chk("R6 addr0 w0", 11'h000, m_a0[0]);
    reg_rd_chk("R6 addr1 w5", 11'h0A4, m_a1[5]);
    reg_rd_chk("R6 desc0 w17", 11'h228, m_d0[17]);
    reg_rd_chk("R6 desc1 w32", 11'h40C, m_d1[32]);
  endtask

  task automatic t_reserved();
    reg_wr(11'h070, 32'hFFFF_FFFF);
    reg_wr(11'h07C, 32'hFFFF_FFFF);
    reg_wr(11'h420, 32'hFFFF_FFFF);
    reg_wr(11'h7FC, 32'hFFFF_FFFF);
    reg_rd_chk("R7 rsvd slot w3", 11'h070, 32'h0);
    reg_rd_chk("R7 rsvd slot 0x1C w3", 11'h07C, 32'h0);
    reg_rd_chk("R7 beyond map", 11'h420, 32'h0);
    reg_rd_chk("R7 w3 addr0 intact", 11'h060, m_a0[3]);
    reg_rd_chk("R7 w3 desc1 intact", 11'h06C, m_d1[3]);
    chk_hit("R7 w3 translate", 32'hFA20_0040, 3);
  endtask

  task automatic t_big();
    chk_hit("R3 w0 low", 32'hF800_0000, 0);
    chk_hit("R3 w0 mid", 32'hF812_3456, 0);
    chk_hit("R3 w0 top", 32'hF9FF_FFFF, 0);
  endtask

  task automatic t_small();
    chk_hit("R4 w1 first", 32'hFA00_0000, 1);
    chk_hit("R4 w1 last", 32'hFA0F_FFFF, 1);
    chk_hit("R4 w2 first", 32'hFA10_0000, 2);
    chk_hit("R4 w17", 32'hFB0A_BCDE, 17);
    chk_hit("R4 w32 top", 32'hFBFF_FFFF, 32);
  endtask

  task automatic t_miss();
    logic [31:0] adrs [3] = '{32'hF7FF_FFFF, 32'hFC00_0000, 32'h0000_1000};
    for (int i = 0; i < 3; i++) begin
      send(adrs[i], 1'b0, 32'h1234_0000 + 32'(i));
      chk("R2 miss flag", 64'(out_miss), 64'd1);
      chk("R2 passthru addr", out_addr, 64'(adrs[i]));
      chk("R2 desc zero", {out_desc1, out_desc0}, 64'd0);
      chk("R2 win zero", 64'(out_win), 64'd0);
      chk("R10 read dir on miss", 64'(out_write), 64'd0);
      chk("R10 wdata on miss", 64'(out_wdata), 64'(32'h1234_0000 + 32'(i)));
    end
  endtask

  task automatic t_timing();
    @(negedge clk);
    chk("R8 idle drains", 64'(out_valid), 64'd0);
    chk("R8 ready when empty", 64'(req_ready), 64'd1);
    send(32'hF800_0010, 1'b0, 32'h0);
    chk("R8 valid after accept", 64'(out_valid), 64'd1);
    @(negedge clk);
    chk("R8 consumed", 64'(out_valid), 64'd0);
  endtask

  task automatic t_backpressure();
    logic [63:0] held;
    out_ready = 1'b0;
    send(32'hFA30_0008, 1'b1, 32'hAAAA_0001);
    held = exp_addr(4, 32'hFA30_0008);
    chk("R9 first out", out_addr, held);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'hFB80_0004; req_write = 1'b0; req_wdata = 32'hBBBB_0002;
    #1 chk("R9 ready low stalled", 64'(req_ready), 64'd0);
    @(negedge clk);
    chk("R9 held addr", out_addr, held);
    chk("R9 held wdata", 64'(out_wdata), 64'h0000_0000_AAAA_0001);
    chk("R9 held valid", 64'(out_valid), 64'd1);
    out_ready = 1'b1;
    #1 chk("R8 ready on drain", 64'(req_ready), 64'd1);
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    chk("R9 second follows", out_addr, exp_addr(25, 32'hFB80_0004));
    chk("R9 second win", 64'(out_win), 64'd25);
    chk("R9 second wdata", 64'(out_wdata), 64'h0000_0000_BBBB_0002);
  endtask

  initial begin
    #100000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_reserved();
    t_big();
    t_small();
    t_miss();
    t_timing();
    t_backpressure();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule